// File: doc/BRIEF.md
# DRAM Row/Column Address Multiplexer

This block sits between a memory controller and a bank of DRAM or VRAM devices. It takes a 32-bit logical word address and drives a 13-bit multiplexed address bus. The row half of the address goes out first and RAS is asserted. The column half follows and CAS is asserted. The strobes are held, and the access ends with a precharge interval.

A two-bit size mode selects the basic device size: 64K, 256K, 1M or 4M. This mode moves the row-time field up the logical address by one bit per step. A column remap select changes only the column-time layout. With the select set, the pins above the mode's active pin count carry the next higher logical bits, so the same pins hold the same bits at row time and at column time. Standard DRAMs can then be wired straight to the low pins, and external decode can use the upper pins.

The block also reports how many address pins the sampled mode uses and how many interleaved 32-bit banks that mode allows. Requests are accepted through a valid/ready handshake. A one-cycle done pulse marks the end of precharge.

Top module: `rca_addr_mux`

## Requirements
- R1: After reset the block shows the following values: req_ready_o=1, ras_n_o=1, cas_n_o=1, done_o=0, rc_addr_o=0, pins_active_o=8 and banks_o=16.
- R2: While RAS is asserted and CAS is not yet asserted, and during the row phase, pin i of rc_addr_o carries logical address bit 12+m+i. Here m is the sampled size mode: 0=64K, 1=256K, 2=1M, 3=4M.
- R3: With the column remap select at 0, pin i of rc_addr_o carries logical bit 4+i during the column, hold and precharge phases, in every mode.
- R4: With the column remap select at 1, pins i < 8+m carry logical bit 4+i and pins i >= 8+m carry bit 12+m+i during the column, hold and precharge phases. This is the default per-mode lookup, in which the upper-pin base bit is 20+2m.
- R5: pins_active_o equals 8+m and banks_o equals 16>>m for the mode sampled at the last accepted request.
- R6: After the accepting edge the strobes follow a fixed sequence. First the row address is driven for T_ASR cycles with both strobes high, then one cycle with RAS low. Next the column address is driven for T_ASC cycles with RAS low, then one cycle with CAS also low. Then come T_HOLD cycles with both strobes low and T_PRE cycles with both strobes high.
- R7: req_ready_o is high only when no access is in progress. done_o is high for exactly one cycle, the last precharge cycle. A request presented while req_ready_o is low starts no access.
- R8: The address, size mode and remap select are sampled only on the accepting edge. Changes to them during an access leave rc_addr_o, pins_active_o and banks_o unchanged until the next accepted request.
- R9: Pins above the active count are never gated. In 64K mode with remap 0, logical bits 12 to 16 appear on pins 0 to 4 at row time and on pins 8 to 12 at column time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request |
| req_ready_o | output | 1 | Block idle, request accepted this cycle if valid |
| req_addr_i | input | 32 | Logical word address |
| size_mode_i | input | 2 | Device size mode (0=64K, 1=256K, 2=1M, 3=4M) |
| col_remap_i | input | 1 | Column-time remap select |
| rc_addr_o | output | 13 | Multiplexed row/column address bus |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| done_o | output | 1 | One-cycle pulse at end of precharge |
| pins_active_o | output | 4 | Address pins used by the sampled mode |
| banks_o | output | 5 | Interleaved banks allowed by the sampled mode |

## Verification
The hardest situation to reach from the ports is a change of mode, remap select and address in the middle of an access. That change must leave the bus untouched. To reach it, the bench starts an access and then, in the row phase, changes all three sampled inputs and holds a fresh request high. It then checks every later phase against the originally sampled values, and confirms that no second access follows done. Because all four modes are run with both remap settings, the boundary between the low pins and the upper pins moves across pins 8 to 11.

// File: rtl/rca_pkg.sv
package rca_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ROW  = 3'd1,
    PH_COL  = 3'd2,
    PH_HOLD = 3'd3,
    PH_PRE  = 3'd4
  } phase_e;

  localparam int unsigned MODES = 4;
endpackage

// File: rtl/rca_bit_map.sv
module rca_bit_map #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PIN_W     = 13,
  parameter int unsigned ROW_BASE  = 12,
  parameter int unsigned COL_BASE  = 4,
  parameter int unsigned MIN_PINS  = 8,
  parameter logic [3:0][7:0] COL_HI_BASE = {8'd26, 8'd24, 8'd22, 8'd20}
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        mode_i,
  input  logic              remap_i,
  output logic [PIN_W-1:0]  row_o,
  output logic [PIN_W-1:0]  col_o
);
  localparam int unsigned IDX_W = $clog2(ADDR_W);

  for (genvar i = 0; i < PIN_W; i++) begin : g_pin
    logic [IDX_W-1:0] row_idx, lo_idx, hi_idx;
    logic             use_hi;
    always_comb begin
      row_idx = IDX_W'(ROW_BASE + i) + IDX_W'(mode_i);
      lo_idx  = IDX_W'(COL_BASE + i);
      hi_idx  = COL_HI_BASE[mode_i][IDX_W-1:0] + IDX_W'(i)
              - IDX_W'(MIN_PINS) - IDX_W'(mode_i);
      use_hi  = remap_i && (IDX_W'(i) >= IDX_W'(MIN_PINS) + IDX_W'(mode_i));
      row_o[i] = addr_i[row_idx];
      col_o[i] = use_hi ? addr_i[hi_idx] : addr_i[lo_idx];
    end
  end
endmodule

// File: rtl/rca_mode_info.sv
module rca_mode_info #(
  parameter int unsigned MIN_PINS  = 8,
  parameter int unsigned MAX_BANKS = 16,
  localparam int unsigned PINS_W  = $clog2(MIN_PINS + 4),
  localparam int unsigned BANKS_W = $clog2(MAX_BANKS + 1)
) (
  input  logic [1:0]         mode_i,
  output logic [PINS_W-1:0]  pins_o,
  output logic [BANKS_W-1:0] banks_o
);
  always_comb begin
    pins_o  = PINS_W'(MIN_PINS) + PINS_W'(mode_i);
    banks_o = BANKS_W'(MAX_BANKS) >> mode_i;
  end
endmodule

// File: rtl/rca_phase_seq.sv
module rca_phase_seq
  import rca_pkg::*;
#(
  parameter int unsigned T_ASR  = 2,
  parameter int unsigned T_ASC  = 2,
  parameter int unsigned T_HOLD = 3,
  parameter int unsigned T_PRE  = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  output phase_e phase_o,
  output logic   ready_o,
  output logic   ras_n_o,
  output logic   cas_n_o,
  output logic   done_o
);
  localparam int unsigned MAX_A = (T_ASR > T_ASC) ? T_ASR : T_ASC;
  localparam int unsigned MAX_B = (T_HOLD > T_PRE) ? T_HOLD : T_PRE;
  localparam int unsigned MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W = $clog2(MAX_T + 1) + 1;

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;

  always_comb begin
    unique case (phase_q)
      PH_ROW:  last = (cnt_q == CNT_W'(T_ASR));
      PH_COL:  last = (cnt_q == CNT_W'(T_ASC));
      PH_HOLD: last = (cnt_q == CNT_W'(T_HOLD - 1));
      PH_PRE:  last = (cnt_q == CNT_W'(T_PRE - 1));
      default: last = 1'b0;
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q + 1'b1;
    unique case (phase_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (start_i) phase_d = PH_ROW;
      end
      PH_ROW:  if (last) begin phase_d = PH_COL;  cnt_d = '0; end
      PH_COL:  if (last) begin phase_d = PH_HOLD; cnt_d = '0; end
      PH_HOLD: if (last) begin phase_d = PH_PRE;  cnt_d = '0; end
      PH_PRE:  if (last) begin phase_d = PH_IDLE; cnt_d = '0; end
      default: begin phase_d = PH_IDLE; cnt_d = '0; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase_o = phase_q;
  assign ready_o = (phase_q == PH_IDLE);
  assign ras_n_o = !((phase_q == PH_ROW && last) || phase_q == PH_COL || phase_q == PH_HOLD);
  assign cas_n_o = !((phase_q == PH_COL && last) || phase_q == PH_HOLD);
  assign done_o  = (phase_q == PH_PRE) && last;
endmodule

// File: rtl/rca_addr_mux.sv
module rca_addr_mux
  import rca_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PIN_W     = 13,
  parameter int unsigned MIN_PINS  = 8,
  parameter int unsigned MAX_BANKS = 16,
  parameter logic [3:0][7:0] COL_HI_BASE = {8'd26, 8'd24, 8'd22, 8'd20},
  parameter int unsigned T_ASR  = 2,
  parameter int unsigned T_ASC  = 2,
  parameter int unsigned T_HOLD = 3,
  parameter int unsigned T_PRE  = 2,
  localparam int unsigned PINS_W  = $clog2(MIN_PINS + 4),
  localparam int unsigned BANKS_W = $clog2(MAX_BANKS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [1:0]         size_mode_i,
  input  logic               col_remap_i,
  output logic [PIN_W-1:0]   rc_addr_o,
  output logic               ras_n_o,
  output logic               cas_n_o,
  output logic               done_o,
  output logic [PINS_W-1:0]  pins_active_o,
  output logic [BANKS_W-1:0] banks_o
);
  logic              start;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        mode_q;
  logic              remap_q;
  logic [PIN_W-1:0]  row_bits, col_bits;
  phase_e            phase;

  assign start = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      mode_q  <= '0;
      remap_q <= 1'b0;
    end else if (start) begin
      addr_q  <= req_addr_i;
      mode_q  <= size_mode_i;
      remap_q <= col_remap_i;
    end
  end

  rca_phase_seq #(
    .T_ASR(T_ASR), .T_ASC(T_ASC), .T_HOLD(T_HOLD), .T_PRE(T_PRE)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .phase_o (phase),
    .ready_o (req_ready_o),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o),
    .done_o  (done_o)
  );

  rca_bit_map #(
    .ADDR_W(ADDR_W), .PIN_W(PIN_W), .MIN_PINS(MIN_PINS), .COL_HI_BASE(COL_HI_BASE)
  ) u_map (
    .addr_i  (addr_q),
    .mode_i  (mode_q),
    .remap_i (remap_q),
    .row_o   (row_bits),
    .col_o   (col_bits)
  );

  rca_mode_info #(
    .MIN_PINS(MIN_PINS), .MAX_BANKS(MAX_BANKS)
  ) u_info (
    .mode_i  (mode_q),
    .pins_o  (pins_active_o),
    .banks_o (banks_o)
  );

  // row field stays on the bus while idle; column field from COL onward
  assign rc_addr_o = (phase == PH_IDLE || phase == PH_ROW) ? row_bits : col_bits;
endmodule

// File: rtl/rca_addr_mux_chk.sv
module rca_addr_mux_chk #(
  parameter int unsigned PIN_W   = 13,
  parameter int unsigned PINS_W  = 4,
  parameter int unsigned BANKS_W = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_ready_o,
  input logic [PIN_W-1:0]   rc_addr_o,
  input logic               ras_n_o,
  input logic               cas_n_o,
  input logic               done_o,
  input logic [PINS_W-1:0]  pins_active_o,
  input logic [BANKS_W-1:0] banks_o
);
  AST_CAS_NEEDS_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_n_o |-> !ras_n_o); // R6

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7

  AST_READY_STROBES_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (ras_n_o && cas_n_o && !done_o)); // R7

  AST_DONE_THEN_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> req_ready_o); // R7

  AST_BUS_STABLE_CAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cas_n_o && $past(!cas_n_o)) |-> $stable(rc_addr_o)); // R8

  AST_INFO_STABLE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o && $past(!ras_n_o)) |-> ($stable(pins_active_o) && $stable(banks_o))); // R8

  AST_PINS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins_active_o >= PINS_W'(8)) && (pins_active_o <= PINS_W'(11))); // R5

  AST_BANKS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(banks_o) && (banks_o != '0)); // R5
endmodule

bind rca_addr_mux rca_addr_mux_chk #(
  .PIN_W(PIN_W), .PINS_W(PINS_W), .BANKS_W(BANKS_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_ready_o   (req_ready_o),
  .rc_addr_o     (rc_addr_o),
  .ras_n_o       (ras_n_o),
  .cas_n_o       (cas_n_o),
  .done_o        (done_o),
  .pins_active_o (pins_active_o),
  .banks_o       (banks_o)
);

// File: tb/rca_addr_mux_bench.sv
module rca_addr_mux_bench;
  localparam int CLK_PERIOD = 10;
  localparam int T_ASR  = 2;
  localparam int T_ASC  = 2;
  localparam int T_HOLD = 3;
  localparam int T_PRE  = 2;
  localparam int TOTAL  = T_ASR + 1 + T_ASC + 1 + T_HOLD + T_PRE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        ready;
  logic [31:0] addr = '0;
  logic [1:0]  mode = '0;
  logic        remap = 1'b0;
  logic [12:0] bus;
  logic        ras_n, cas_n, done;
  logic [3:0]  pins;
  logic [4:0]  banks;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rca_addr_mux u_rca_addr_mux (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_addr_i(addr), .size_mode_i(mode), .col_remap_i(remap),
    .rc_addr_o(bus), .ras_n_o(ras_n), .cas_n_o(cas_n), .done_o(done),
    .pins_active_o(pins), .banks_o(banks)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [12:0] exp_row(input logic [31:0] a, input int m);
    logic [12:0] r;
    for (int i = 0; i < 13; i++) r[i] = a[12 + m + i];
    return r;
  endfunction

  function automatic logic [12:0] exp_col(input logic [31:0] a, input int m, input logic c);
    logic [12:0] r;
    for (int i = 0; i < 13; i++)
      r[i] = (c && i >= 8 + m) ? a[12 + m + i] : a[4 + i];
    return r;
  endfunction

  // runs one access; optionally disturbs the sampled inputs at j==1
  task automatic run_access(input logic [31:0] a, input int m, input logic c,
                            input bit disturb, input string tag);
    logic [12:0] er, ec;
    logic        eras, ecas;
    er = exp_row(a, m);
    ec = exp_col(a, m, c);
    @(negedge clk);
    addr = a; mode = 2'(m); remap = c; valid = 1'b1;
    @(posedge clk);
    for (int j = 0; j < TOTAL; j++) begin
      @(negedge clk);
      if (j == 0 && !disturb) valid = 1'b0;
      if (j == 1 && disturb) begin
        addr = ~a; mode = 2'(m + 1); remap = ~c;
      end
      if (j == TOTAL - 2 && disturb) valid = 1'b0;
      eras = !((j == T_ASR) || (j > T_ASR && j < T_ASR + 1 + T_ASC + 1 + T_HOLD));
      ecas = !(j >= T_ASR + 1 + T_ASC && j < T_ASR + 1 + T_ASC + 1 + T_HOLD);
      chk({tag, " R6 ras_n"}, 32'(ras_n), 32'(eras));
      chk({tag, " R6 cas_n"}, 32'(cas_n), 32'(ecas));
      chk({tag, " R7 ready busy"}, 32'(ready), 32'(0));
      chk({tag, " R7 done"}, 32'(done), 32'(j == TOTAL - 1));
      if (j <= T_ASR) chk({tag, " R2 row bus"}, 32'(bus), 32'(er));
      else if (c)     chk({tag, " R4 remap col bus"}, 32'(bus), 32'(ec));
      else            chk({tag, " R3 col bus"}, 32'(bus), 32'(ec));
      chk({tag, " R5 pins R8"}, 32'(pins), 32'(8 + m));
      chk({tag, " R5 banks R8"}, 32'(banks), 32'(16 >> m));
    end
    @(negedge clk);
    chk({tag, " R7 ready after done"}, 32'(ready), 32'(1));
    chk({tag, " R7 no second access"}, 32'(ras_n), 32'(1));
    chk({tag, " R8 idle bus keeps row"}, 32'(bus), 32'(er));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 ready", 32'(ready), 32'(1));
    chk("R1 ras_n", 32'(ras_n), 32'(1));
    chk("R1 cas_n", 32'(cas_n), 32'(1));
    chk("R1 done", 32'(done), 32'(0));
    chk("R1 bus", 32'(bus), 32'(0));
    chk("R1 pins", 32'(pins), 32'(8));
    chk("R1 banks", 32'(banks), 32'(16));
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_all_modes();
    logic [31:0] pats[3] = '{32'hA5C3_96F0, 32'h0F0F_F0F0, 32'h1234_5678};
    for (int p = 0; p < 3; p++)
      for (int m = 0; m < 4; m++)
        for (int c = 0; c < 2; c++)
          run_access(pats[p], m, 1'(c), 1'b0, $sformatf("mode%0d remap%0d", m, c));
  endtask

  task automatic t_dup_64k();
    // R9: bits 12..16 set alone, seen at row pins 0..4 and column pins 8..12
    logic [31:0] a;
    a = 32'h0001_F000;
    run_access(a, 0, 1'b0, 1'b0, "R9 dup");
    chk("R9 row pins 0-4", 32'(exp_row(a, 0)), 32'h001F);
    chk("R9 col pins 8-12", 32'(exp_col(a, 0, 1'b0)), 32'h1F00);
  endtask

  task automatic t_midchange();
    run_access(32'hDEAD_BEEF, 1, 1'b1, 1'b1, "R8 midchange");
    run_access(32'h7654_3210, 3, 1'b0, 1'b1, "R8 midchange2");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_all_modes();
        t_dup_64k();
        t_midchange();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule